// File: doc/BRIEF.md
# Stereo PCM Attenuator with Soft Mute

This block scales a stereo PCM stream by a programmable attenuation. Each channel takes an 8-bit code in half-decibel steps, from unity gain down to -127.5 dB. A tracking flag makes the left code drive both channels, so a single control moves the stereo image as one.

A soft-mute input does not cut the signal at once. While mute is high, the attenuation of each channel grows by one half-decibel step on every incoming sample until it reaches the largest code, and from then on the output is exactly zero. When mute is released, the attenuation falls by one step per sample until it is back at the programmed setting.

Samples enter with a valid strobe and leave two clock cycles later with their own valid strobe. Gain is formed from a right shift of one bit per 6 dB (twelve codes) and a stored fractional factor for the remaining 0 to 11 half-decibel steps. Each product is rounded toward zero.

Top module: `stereo_atten`

## Requirements
- R1: A sample scaled by effective code N (0..255) gives trunc(sample * F[N mod 12] / 2^(15 + N div 12)), where F[r] = round(32768 * 10^(-r/40)) and trunc rounds toward zero; code 0 passes the sample unchanged.
- R2: During and after reset: out_valid is 0, both outputs are 0, and both effective codes are 0 (unity gain).
- R3: With track = 0, the left channel follows atten_left and the right channel follows atten_right, each on its own.
- R4: With track = 1, atten_left sets the target of both channels, and atten_right has no effect on the output.
- R5: out_valid is high exactly two clock cycles after in_valid is high, and out_left and out_right hold their values while out_valid is low.
- R6: While mute is 1, each accepted sample raises the channel's effective code by one, and the code stops at 255.
- R7: A sample accepted with mute = 1 that brings the effective code to 255 produces an output of exactly 0.
- R8: While mute is 0, an accepted sample lowers an effective code that is above its target by one. An effective code at or below its target takes the target value at once.
- R9: Effective codes change only on cycles with in_valid = 1, so a gap in the stream pauses a mute ramp or a release ramp.
- R10: The magnitude of an output never exceeds the magnitude of its input sample, including for the most negative input, and each output saturates to the 24-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample pair present |
| in_left | input | 24 | Left sample, signed two's complement |
| in_right | input | 24 | Right sample, signed two's complement |
| atten_left | input | 8 | Left attenuation code, 0.5 dB per step |
| atten_right | input | 8 | Right attenuation code, 0.5 dB per step |
| track | input | 1 | 1: left code drives both channels |
| mute | input | 1 | 1: ramp toward silence; 0: ramp back |
| out_valid | output | 1 | Output sample pair present |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
Codes are swept across the twelve fractional positions and across the shift boundaries (11, 12, 13, 23, 24, 254, 255). The inputs include full-scale positive, the most negative value, and the values +1 and -1. Together these separate an error in the fractional table from an error in the shift, and rounding toward zero from rounding toward minus infinity. Tracking runs use left and right codes that differ, so any leak from atten_right shows. A long mute run followed by a release checks the step count to silence and back. The same ramps are then run with gaps in the valid strobe, which shows whether the ramp is counted per sample or per clock.

// File: rtl/stereo_atten_pkg.sv
// Package: shared constants and the fractional gain table of the attenuator.
// Assumes a 16-bit unsigned Q1.15 factor, where 32768 stands for unity.
package stereo_atten_pkg;

    localparam int STEPS_PER_SHIFT = 12;
    localparam int COEF_W          = 16;

    // Returns round(32768 * 10^(-idx/40)) for the half-decibel remainder idx.
    function automatic logic [COEF_W-1:0] frac_gain(input logic [3:0] idx);
        case (idx)
            4'd0:    frac_gain = 16'd32768;
            4'd1:    frac_gain = 16'd30935;
            4'd2:    frac_gain = 16'd29205;
            4'd3:    frac_gain = 16'd27571;
            4'd4:    frac_gain = 16'd26029;
            4'd5:    frac_gain = 16'd24573;
            4'd6:    frac_gain = 16'd23198;
            4'd7:    frac_gain = 16'd21900;
            4'd8:    frac_gain = 16'd20675;
            4'd9:    frac_gain = 16'd19519;
            4'd10:   frac_gain = 16'd18427;
            default: frac_gain = 16'd17396;
        endcase
    endfunction

endpackage

// File: rtl/atten_code_ctrl.sv
// Module: per-channel effective attenuation code with soft-mute ramping.
// Also acts as pipeline stage 1: it captures the sample together with the
// code that applies to it. Everything advances only on accepted samples.
module atten_code_ctrl #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic                     mute_i,
    input  logic [CODE_W-1:0]        target_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic [CODE_W-1:0]        code_o,
    output logic                     zero_o,
    output logic signed [DATA_W-1:0] sample_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] code_nxt;

    // Next code: ramp up under mute, ramp down toward the target, or jump up to it.
    always_comb begin
        if (mute_i) begin
            code_nxt = (code_o == CODE_MAX) ? CODE_MAX : code_o + CODE_W'(1);
        end else if (code_o > target_i) begin
            code_nxt = code_o - CODE_W'(1);
        end else begin
            code_nxt = target_i;
        end
    end

    // Register the code, the zero flag and the sample on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            zero_o   <= 1'b0;
            sample_o <= '0;
        end else if (valid_i) begin
            code_o   <= code_nxt;
            zero_o   <= mute_i && (code_nxt == CODE_MAX);
            sample_o <= sample_i;
        end
    end

endmodule

// File: rtl/atten_gain_scale.sv
// Module: multiplies a sample by the gain of a code (fraction times power-of-two
// shift), rounds toward zero, saturates and registers the result (stage 2).
// Assumes the code stays stable from stage 1 while valid_i is high.
module atten_gain_scale
    import stereo_atten_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     zero_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] result_o
);
    localparam int PROD_W  = DATA_W + COEF_W + 1;
    localparam int SHIFT_W = $clog2(COEF_W + 1 + (2**CODE_W) / STEPS_PER_SHIFT);
    localparam logic signed [PROD_W-1:0] S_MAX =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] S_MIN =
        {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] ONE = PROD_W'(1);

    logic [3:0]                idx;
    logic [SHIFT_W-1:0]        shamt;
    logic signed [PROD_W-1:0]  samp_x;
    logic signed [PROD_W-1:0]  coef_x;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  bias;
    logic signed [PROD_W-1:0]  scaled;
    logic signed [DATA_W-1:0]  clipped;

    // Split the code into a table index and a total right-shift amount.
    always_comb begin
        idx   = 4'(code_i % CODE_W'(STEPS_PER_SHIFT));
        shamt = SHIFT_W'(COEF_W - 1) + SHIFT_W'(code_i / CODE_W'(STEPS_PER_SHIFT));
    end

    // Multiply, then bias negative products so the shift truncates toward zero.
    always_comb begin
        samp_x = PROD_W'(sample_i);
        coef_x = $signed({{(PROD_W-COEF_W){1'b0}}, frac_gain(idx)});
        prod   = samp_x * coef_x;
        bias   = prod[PROD_W-1] ? ((ONE <<< shamt) - ONE) : '0;
        scaled = (prod + bias) >>> shamt;
    end

    // Clamp to the output range.
    always_comb begin
        if (scaled > S_MAX) begin
            clipped = S_MAX[DATA_W-1:0];
        end else if (scaled < S_MIN) begin
            clipped = S_MIN[DATA_W-1:0];
        end else begin
            clipped = scaled[DATA_W-1:0];
        end
    end

    // Register the result on valid; force silence when the zero flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (valid_i) begin
            result_o <= zero_i ? '0 : clipped;
        end
    end

endmodule

// File: rtl/stereo_atten.sv
// Module: stereo attenuator with tracking mode and soft mute.
// Two-stage pipeline: code update and capture, then scaling. Assumes the
// attenuation codes, track and mute are sampled with each valid input.
module stereo_atten #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic [CODE_W-1:0]        atten_left,
    input  logic [CODE_W-1:0]        atten_right,
    input  logic                     track,
    input  logic                     mute,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    localparam int NCH = 2;

    logic [CODE_W-1:0]        tgt   [NCH];
    logic signed [DATA_W-1:0] samp  [NCH];
    logic [CODE_W-1:0]        code  [NCH];
    logic                     zero  [NCH];
    logic signed [DATA_W-1:0] s1_smp[NCH];
    logic signed [DATA_W-1:0] res   [NCH];
    logic                     s1_valid;
    logic [CODE_W-1:0]        code_l;
    logic [CODE_W-1:0]        code_r;

    // Pick per-channel targets and samples; tracking routes the left code right.
    always_comb begin
        tgt[0]  = atten_left;
        tgt[1]  = track ? atten_left : atten_right;
        samp[0] = in_left;
        samp[1] = in_right;
    end

    // Pipeline valid flags for both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        atten_code_ctrl #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_code (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid_i  (in_valid),
            .mute_i   (mute),
            .target_i (tgt[ch]),
            .sample_i (samp[ch]),
            .code_o   (code[ch]),
            .zero_o   (zero[ch]),
            .sample_o (s1_smp[ch])
        );
        atten_gain_scale #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_scale (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid_i  (s1_valid),
            .code_i   (code[ch]),
            .zero_i   (zero[ch]),
            .sample_i (s1_smp[ch]),
            .result_o (res[ch])
        );
    end

    // Expose results and effective codes under channel names.
    always_comb begin
        out_left  = res[0];
        out_right = res[1];
        code_l    = code[0];
        code_r    = code[1];
    end

endmodule

// File: rtl/stereo_atten_chk.sv
// Checker: temporal properties of the stereo attenuator, bound to the top.
// Assumes the top exposes its effective codes as code_l and code_r.
module stereo_atten_chk #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic [CODE_W-1:0]        atten_left,
    input logic                     track,
    input logic                     mute,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right,
    input logic [CODE_W-1:0]        code_l,
    input logic [CODE_W-1:0]        code_r
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [1:0] age;

    // Count cycles since reset (saturating) so $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
        logic signed [DATA_W:0] w;
        w = v;
        mag = (w < 0) ? -w : w;
    endfunction

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

    a_r6_mute_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute) |=>
        (code_l == (($past(code_l) == CODE_MAX) ? CODE_MAX : $past(code_l) + CODE_W'(1))));

    a_r8_release_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute && code_l > atten_left) |=> (code_l == $past(code_l) - CODE_W'(1)));

    a_r4_track_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute && track && code_r <= atten_left) |=> (code_r == $past(atten_left)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(code_l) && $stable(code_r)));

    a_r10_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid) |-> (mag(out_left) <= mag($past(in_left, 2))));

endmodule

bind stereo_atten stereo_atten_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_left    (in_left),
    .atten_left (atten_left),
    .track      (track),
    .mute       (mute),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right),
    .code_l     (code_l),
    .code_r     (code_r)
);

// File: tb/test_stereo_atten.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (integers, per-channel code state and a
// two-entry expected-output delay) compared with the design on every clock.
module test_stereo_atten;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0, in_right = '0;
    logic [7:0] atten_left = '0, atten_right = '0;
    logic track = 1'b0, mute = 1'b0;
    logic out_valid;
    logic signed [DW-1:0] out_left, out_right;

    int checks = 0, errors = 0;
    string tag = "R2";
    bit done = 1'b0;

    stereo_atten i_stereo_atten (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .atten_left(atten_left), .atten_right(atten_right),
        .track(track), .mute(mute),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    always #2.5 clk = ~clk;

    // Reference gain per R1: truncating division by 2^(15 + N/12) after the factor.
    function automatic longint ref_scale(input longint s, input int code);
        longint c, p;
        c = longint'($rtoi(32768.0 * (10.0 ** (-(code % 12) / 40.0)) + 0.5));
        p = s * c;
        return p / (longint'(1) << (15 + code / 12));
    endfunction

    int mc[2];
    bit m1v, m2v;
    longint m1[2], m2[2];

    // Model of R2..R10 advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mc = '{0, 0}; m1v = 0; m2v = 0; m1 = '{0, 0}; m2 = '{0, 0};
        end else begin
            m2v = m1v;
            if (m1v) m2 = m1;
            m1v = in_valid;
            if (in_valid) begin
                for (int ch = 0; ch < 2; ch++) begin
                    int t;
                    longint s;
                    t = (ch == 0 || track) ? int'(atten_left) : int'(atten_right);
                    s = (ch == 0) ? longint'(in_left) : longint'(in_right);
                    if (mute) mc[ch] = (mc[ch] < 255) ? mc[ch] + 1 : 255;
                    else if (mc[ch] > t) mc[ch] = mc[ch] - 1;
                    else mc[ch] = t;
                    m1[ch] = (mute && mc[ch] == 255) ? 0 : ref_scale(s, mc[ch]);
                end
            end
        end
    end

    // Compare all outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== m2v || longint'(out_left) != m2[0] || longint'(out_right) != m2[1]) begin
                errors++;
                $display("FAIL %s: actual v=%0b L=%0d R=%0d expected v=%0b L=%0d R=%0d",
                         tag, out_valid, out_left, out_right, m2v, m2[0], m2[1]);
            end
        end
    end

    task automatic put(input bit v, input logic signed [DW-1:0] l, input logic signed [DW-1:0] r);
        @(negedge clk);
        in_valid = v; in_left = l; in_right = r;
    endtask

    task automatic rnd_sample(input bit v);
        put(v, DW'($urandom), DW'($urandom));
    endtask

    localparam logic signed [DW-1:0] PMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] NMIN = {1'b1, {(DW-1){1'b0}}};

    initial begin
        int codes[12] = '{0, 1, 5, 11, 12, 13, 23, 24, 100, 200, 254, 255};
        repeat (4) @(negedge clk);               // R2 reset state compared each cycle
        rst_n = 1'b1;
        tag = "R2";
        put(1'b0, '0, '0);
        // R1 / R3 / R10: code sweep with edge and random samples, independent channels
        tag = "R1_R3_R10";
        foreach (codes[i]) begin
            atten_left = 8'(codes[i]);
            atten_right = 8'(codes[11 - i]);
            repeat (2) put(1'b1, PMAX, NMIN);
            put(1'b1, NMIN, PMAX);
            put(1'b1, -24'sd1, 24'sd1);
            put(1'b1, 24'sd1, -24'sd1);
            repeat (4) rnd_sample(1'b1);
            put(1'b0, PMAX, PMAX);
        end
        // R8: lowering the code ramps step by step, raising it jumps
        tag = "R8";
        atten_left = 8'd0; atten_right = 8'd40;
        repeat (300) rnd_sample(1'b1);
        // R4: tracking, atten_right varied and must not matter
        tag = "R4";
        track = 1'b1; atten_left = 8'd30;
        for (int k = 0; k < 40; k++) begin
            atten_right = 8'($urandom);
            rnd_sample(1'b1);
        end
        atten_left = 8'd7;
        repeat (40) rnd_sample(1'b1);
        track = 1'b0;
        // R6 / R7: soft mute ramp to silence, then hold
        tag = "R6_R7";
        atten_left = 8'd10; atten_right = 8'd3;
        repeat (5) rnd_sample(1'b1);
        mute = 1'b1;
        repeat (270) put(1'b1, PMAX, NMIN);
        // R8: release back to the programmed codes
        tag = "R8";
        mute = 1'b0;
        repeat (260) put(1'b1, NMIN, PMAX);
        // R9 / R5: ramps with gaps in the strobe
        tag = "R9_R5";
        mute = 1'b1;
        for (int k = 0; k < 120; k++) rnd_sample(k % 3 == 0);
        mute = 1'b0;
        for (int k = 0; k < 120; k++) rnd_sample(k % 2 == 0);
        repeat (4) put(1'b0, '0, '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule